// File: doc/BRIEF.md
# Nibble Accumulator Processor

A small processor core that works on 4-bit data. Its program store is read-only and separate from its data store: instruction words come from a constant image given as a parameter, while data lives in a sixteen-entry table of 4-bit words inside the core. The only working register is one 4-bit accumulator. A data pointer register selects the data word being read or written.

Every 8-bit instruction word has an opcode in its upper nibble and an operand in its lower nibble. A single operand selector chooses between that literal nibble and the data word under the pointer. The ALU reads its second input through this selector. The same selected value can also load the program counter, for jumps, or the data pointer.

Each instruction takes three clock cycles: fetch, decode, execute. A step mode lets an external request release exactly one instruction at a time. Debug outputs show the program counter, the data pointer and the accumulator, and a one-cycle pulse marks the cycle in which an instruction commits.

Top module: `nib_cpu`

## Requirements
- R1: While `rst_n` is low, and in the cycle it is released, `dbg_pc`, `dbg_addr` and `dbg_acc` read 0 and `retire` is low. The first instruction executed is the one at program address 0.
- R2: With `step_mode` low, `retire` is high for exactly one cycle in every three, and each pulse commits one instruction.
- R3: Instruction bits [7:4] are the opcode and bits [3:0] are the operand. Opcodes 0x0 to 0x9 come in pairs that write an ALU result to the accumulator: load (0/1), add (2/3), subtract (4/5), AND (6/7) and XOR (8/9). The even code of each pair uses the literal operand. The odd code uses the data word at the pointer.
- R4: Add and subtract give their result modulo 16.
- R5: Opcode 0xA writes the accumulator into the data word at the pointer. A later memory-operand instruction reads that value back.
- R6: Opcode 0xB loads the data pointer from the literal operand. Opcode 0xC loads it from the data word at the current pointer.
- R7: Every instruction that does not jump advances the program counter by one, modulo 16.
- R8: Opcode 0xD always jumps to the literal operand and opcode 0xF always jumps to the data word at the pointer. Opcode 0xE jumps to the literal operand only if the accumulator is zero; otherwise it falls through to the next address.
- R9: While `step_mode` is high, a new instruction starts only in a cycle where `step_req` is high at fetch. With no request, the program counter, pointer and accumulator hold and `retire` stays low.
- R10: The effects of an instruction appear on the debug outputs in the cycle after its `retire` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_mode | input | 1 | 1 = run one instruction per step request |
| step_req | input | 1 | Step request, sampled in the fetch phase |
| dbg_pc | output | 4 | Program counter |
| dbg_addr | output | 4 | Data pointer |
| dbg_acc | output | 4 | Accumulator |
| retire | output | 1 | High in the execute cycle of each instruction |

## Verification
The test program is built to hit wrap-around in both directions. It adds 9 to 9 and subtracts 3 from 2, so a core with a wider adder or without modulo arithmetic gives the wrong accumulator value. The program sets the pointer from a stored data word and then reads through it. A selector that routed the literal in place of the data word would then compute a wrong sum and a wrong XOR. The conditional jump runs both taken and not taken, which catches a test that is inverted or ignored, and the step-mode gaps of random length show any core that runs ahead without a request or misses one.

// File: rtl/nib_cpu_pkg.sv
package nib_cpu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [1:0] {
    PH_FETCH  = 2'd0,
    PH_DECODE = 2'd1,
    PH_EXEC   = 2'd2
  } phase_e;

  typedef enum logic [2:0] {
    FN_PASS = 3'd0,
    FN_ADD  = 3'd1,
    FN_SUB  = 3'd2,
    FN_AND  = 3'd3,
    FN_XOR  = 3'd4
  } alu_fn_e;

  typedef struct packed {
    alu_fn_e fn;
    logic    sel_ram;   // operand selector: 1 = data word, 0 = literal
    logic    wr_acc;
    logic    wr_ram;
    logic    wr_addr;
    logic    jump;
    logic    jz;        // jump only when accumulator is zero
  } ctrl_t;

  // Control table indexed by opcode
  function automatic ctrl_t decode_op(input logic [OP_W-1:0] op);
    ctrl_t c;
    c = '0;
    c.fn = FN_PASS;
    case (op)
      4'h0, 4'h1: c.wr_acc = 1'b1;
      4'h2, 4'h3: begin c.fn = FN_ADD; c.wr_acc = 1'b1; end
      4'h4, 4'h5: begin c.fn = FN_SUB; c.wr_acc = 1'b1; end
      4'h6, 4'h7: begin c.fn = FN_AND; c.wr_acc = 1'b1; end
      4'h8, 4'h9: begin c.fn = FN_XOR; c.wr_acc = 1'b1; end
      4'hA:       c.wr_ram = 1'b1;
      4'hB:       c.wr_addr = 1'b1;
      4'hC:       begin c.wr_addr = 1'b1; c.sel_ram = 1'b1; end
      4'hD:       c.jump = 1'b1;
      4'hE:       begin c.jump = 1'b1; c.jz = 1'b1; end
      default:    begin c.jump = 1'b1; c.sel_ram = 1'b1; end
    endcase
    if (op <= 4'h9) c.sel_ram = op[0];
    return c;
  endfunction

endpackage

// File: rtl/nib_cpu_alu.sv
module nib_cpu_alu
  import nib_cpu_pkg::*;
#(
  parameter int DW = 4
) (
  input  alu_fn_e       fn,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);

  function automatic logic [DW-1:0] alu_eval(input alu_fn_e f,
                                             input logic [DW-1:0] x,
                                             input logic [DW-1:0] z);
    case (f)
      FN_ADD:  return x + z;
      FN_SUB:  return x - z;
      FN_AND:  return x & z;
      FN_XOR:  return x ^ z;
      default: return z;
    endcase
  endfunction

  assign y = alu_eval(fn, a, b);

  always_comb begin
    if (fn == FN_PASS) p_pass_r3: assert (y == b);
  end

endmodule

// File: rtl/nib_cpu_dmem.sv
module nib_cpu_dmem #(
  parameter int DW    = 4,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata
);

  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

  logic [AW-1:0] last_addr;
  logic [DW-1:0] last_data;
  logic          last_we;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_we   <= 1'b0;
      last_addr <= '0;
      last_data <= '0;
    end else begin
      last_we   <= we;
      last_addr <= addr;
      last_data <= wdata;
    end
  end

  // R5: a written word reads back at the same address
  p_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    last_we |-> (mem[last_addr] == last_data));

endmodule

// File: rtl/nib_cpu_ctrl.sv
module nib_cpu_ctrl
  import nib_cpu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_mode,
  input  logic            step_req,
  input  logic [OP_W-1:0] op,
  output logic            fetch_fire,
  output logic            decode_fire,
  output logic            exec_fire,
  output logic            dec_sel_ram,
  output ctrl_t           ctrl_q
);

  phase_e phase_q;
  ctrl_t  dec_now;

  assign fetch_fire  = (phase_q == PH_FETCH) && (!step_mode || step_req);
  assign decode_fire = (phase_q == PH_DECODE);
  assign exec_fire   = (phase_q == PH_EXEC);

  assign dec_now     = decode_op(op);
  assign dec_sel_ram = dec_now.sel_ram;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FETCH;
      ctrl_q  <= '0;
    end else begin
      case (phase_q)
        PH_FETCH:  if (fetch_fire) phase_q <= PH_DECODE;
        PH_DECODE: begin
          phase_q <= PH_EXEC;
          ctrl_q  <= dec_now;
        end
        default:   phase_q <= PH_FETCH;
      endcase
    end
  end

  // R2: decode is always followed by execute, execute by fetch
  p_decode_to_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DECODE) |=> (phase_q == PH_EXEC));
  p_exec_to_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_EXEC) |=> (phase_q == PH_FETCH));
  // R9: no request in step mode keeps the core in fetch
  p_step_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FETCH && step_mode && !step_req) |=> (phase_q == PH_FETCH));

endmodule

// File: rtl/nib_cpu.sv
module nib_cpu
  import nib_cpu_pkg::*;
#(
  parameter int DW = 4,
  parameter logic [(2**DW)*(OP_W+DW)-1:0] PROG_IMAGE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_mode,
  input  logic          step_req,
  output logic [DW-1:0] dbg_pc,
  output logic [DW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_acc,
  output logic          retire
);

  localparam int IW    = OP_W + DW;
  localparam int DEPTH = 2**DW;

  logic [DW-1:0] pc_q, acc_q, addr_q, opnd_q;
  logic [IW-1:0] ir_q, rom_word;
  logic [DW-1:0] ram_rd, alu_y, opnd_mux, pc_next;
  logic          fetch_fire, decode_fire, exec_fire, sel_ram;
  logic          jump_taken, acc_zero;
  ctrl_t         ctrl_q;

  // Program store read port
  assign rom_word = PROG_IMAGE[pc_q*IW +: IW];

  nib_cpu_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_mode   (step_mode),
    .step_req    (step_req),
    .op          (ir_q[IW-1:DW]),
    .fetch_fire  (fetch_fire),
    .decode_fire (decode_fire),
    .exec_fire   (exec_fire),
    .dec_sel_ram (sel_ram),
    .ctrl_q      (ctrl_q)
  );

  nib_cpu_dmem #(.DW(DW), .DEPTH(DEPTH)) u_dmem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (exec_fire && ctrl_q.wr_ram),
    .addr  (addr_q),
    .wdata (acc_q),
    .rdata (ram_rd)
  );

  nib_cpu_alu #(.DW(DW)) u_alu (
    .fn (ctrl_q.fn),
    .a  (acc_q),
    .b  (opnd_q),
    .y  (alu_y)
  );

  // Single operand selector shared by ALU, PC and pointer loads
  assign opnd_mux   = sel_ram ? ram_rd : ir_q[DW-1:0];
  assign acc_zero   = (acc_q == '0);
  assign jump_taken = exec_fire && ctrl_q.jump && (!ctrl_q.jz || acc_zero);
  assign pc_next    = jump_taken ? opnd_q : pc_q + DW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      acc_q  <= '0;
      addr_q <= '0;
      opnd_q <= '0;
      ir_q   <= '0;
    end else begin
      if (fetch_fire)  ir_q   <= rom_word;
      if (decode_fire) opnd_q <= opnd_mux;
      if (exec_fire) begin
        pc_q <= pc_next;
        if (ctrl_q.wr_acc)  acc_q  <= alu_y;
        if (ctrl_q.wr_addr) addr_q <= opnd_q;
      end
    end
  end

  assign dbg_pc   = pc_q;
  assign dbg_addr = addr_q;
  assign dbg_acc  = acc_q;
  assign retire   = exec_fire;

  // R7: PC moves only when an instruction commits
  p_pc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_fire |=> $stable(pc_q));
  // R7: fall-through advances by one
  p_pc_incr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && !jump_taken) |=> (pc_q == $past(pc_q) + DW'(1)));
  // R8: taken jump lands on the selected operand
  p_jump_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    jump_taken |=> (pc_q == $past(opnd_q)));
  // R8: conditional jump with nonzero accumulator falls through
  p_jz_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && ctrl_q.jz && !acc_zero) |=> (pc_q == $past(pc_q) + DW'(1)));
  // R3: accumulator changes only on an ALU-writing commit
  p_acc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_fire && ctrl_q.wr_acc) |=> $stable(acc_q));
  // R6: pointer changes only on a pointer-writing commit
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_fire && ctrl_q.wr_addr) |=> $stable(addr_q));

endmodule

// File: tb/nib_cpu_test.sv
`timescale 1ns/1ps
module nib_cpu_test;

  localparam logic [127:0] IMG = {
    8'hD0, 8'hED, 8'h07, 8'hEE, 8'h6E, 8'h90, 8'h30, 8'hC0,
    8'hB5, 8'hA0, 8'hB2, 8'h43, 8'hA0, 8'hB5, 8'h29, 8'h09
  };

  logic clk = 1'b0;
  logic rst_n, step_mode, step_req;
  logic [3:0] dbg_pc, dbg_addr, dbg_acc;
  logic retire;

  always #2 clk = ~clk;

  nib_cpu #(.DW(4), .PROG_IMAGE(IMG)) uut (
    .clk(clk), .rst_n(rst_n), .step_mode(step_mode), .step_req(step_req),
    .dbg_pc(dbg_pc), .dbg_addr(dbg_addr), .dbg_acc(dbg_acc), .retire(retire)
  );

  int checks = 0;
  int fails  = 0;
  bit hung   = 1'b0;
  bit done   = 1'b0;

  logic [7:0] prog_w [16];
  logic [3:0] m_pc, m_acc, m_addr;
  logic [3:0] m_ram [16];

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [3:0] op);
    if (op >= 4'h2 && op <= 4'h5) return "R4";
    if (op <= 4'h9) return "R3";
    if (op == 4'hA) return "R5";
    if (op == 4'hB || op == 4'hC) return "R6";
    return "R8";
  endfunction

  // Reference: one instruction of the architecture
  task automatic model_exec(output logic [3:0] op);
    logic [3:0] imm, mv;
    op  = prog_w[m_pc][7:4];
    imm = prog_w[m_pc][3:0];
    mv  = m_ram[m_addr];
    m_pc = m_pc + 4'd1;
    case (op)
      4'h0: m_acc = imm;
      4'h1: m_acc = mv;
      4'h2: m_acc = 4'((m_acc + imm) % 16);
      4'h3: m_acc = 4'((m_acc + mv) % 16);
      4'h4: m_acc = 4'((m_acc + 16 - imm) % 16);
      4'h5: m_acc = 4'((m_acc + 16 - mv) % 16);
      4'h6: m_acc = m_acc & imm;
      4'h7: m_acc = m_acc & mv;
      4'h8: m_acc = m_acc ^ imm;
      4'h9: m_acc = m_acc ^ mv;
      4'hA: m_ram[m_addr] = m_acc;
      4'hB: m_addr = imm;
      4'hC: m_addr = mv;
      4'hD: m_pc = imm;
      4'hE: if (m_acc == 4'd0) m_pc = imm;
      default: m_pc = mv;
    endcase
  endtask

  task automatic wait_retire(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!retire && n < 24);
    if (!retire) begin
      hung = 1'b1;
      chk(1'b0, "R2 watchdog: no retire", n, 3);
    end
  endtask

  task automatic run_one(input bit free);
    int n;
    logic [3:0] op;
    wait_retire(n);
    if (hung) return;
    if (free) chk(n + 1 == 3, "R2 retire period", n + 1, 3);
    @(negedge clk);
    model_exec(op);
    chk(dbg_acc == m_acc, $sformatf("R10 acc %s op=%0h", op_tag(op), op), dbg_acc, m_acc);
    chk(dbg_addr == m_addr, $sformatf("R10 ptr R6 op=%0h", op), dbg_addr, m_addr);
    chk(dbg_pc == m_pc, $sformatf("R10 pc %s op=%0h",
        (op >= 4'hD) ? "R8" : "R7", op), dbg_pc, m_pc);
    chk(retire == 1'b0, "R2 retire single cycle", retire, 0);
  endtask

  task automatic step_gap_and_pulse();
    int gap;
    gap = 1 + int'($urandom % 5);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk(retire == 1'b0, "R9 no retire without request", retire, 0);
      chk({dbg_pc, dbg_addr, dbg_acc} == {m_pc, m_addr, m_acc},
          "R9 state holds without request",
          {dbg_pc, dbg_addr, dbg_acc}, {m_pc, m_addr, m_acc});
    end
    step_req = 1'b1;
    @(negedge clk);
    step_req = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4177));
    for (int i = 0; i < 16; i++) prog_w[i] = IMG[i*8 +: 8];
    for (int i = 0; i < 16; i++) m_ram[i] = 4'd0;
    rst_n = 1'b0; step_mode = 1'b0; step_req = 1'b0;
    repeat (3) @(negedge clk);
    chk({dbg_pc, dbg_addr, dbg_acc, retire} == 13'd0, "R1 reset state",
        {dbg_pc, dbg_addr, dbg_acc, retire}, 0);
    rst_n = 1'b1;
    m_pc = 4'd0; m_acc = 4'd0; m_addr = 4'd0;
    chk({dbg_pc, dbg_addr, dbg_acc, retire} == 13'd0, "R1 state at release",
        {dbg_pc, dbg_addr, dbg_acc, retire}, 0);

    // Free-running: several passes through the program (R4 wrap, R5, R6, R8 both ways)
    for (int k = 0; k < 48 && !hung; k++) run_one(1'b1);

    // Step mode with random gaps
    step_mode = 1'b1;
    for (int k = 0; k < 24 && !hung; k++) begin
      step_gap_and_pulse();
      run_one(1'b0);
    end

    // Random mix of the two modes
    for (int k = 0; k < 40 && !hung; k++) begin
      step_mode = $urandom % 2;
      if (step_mode) begin
        step_gap_and_pulse();
        run_one(1'b0);
      end else begin
        run_one(1'b1);
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R2 global watchdog actual=%0d expected=%0d", 20000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule